// File: doc/BRIEF.md
# Host Bus Interface Unit

This block sits between a general host bus and a banked register window plus a data-path port. The host presents an address with an address strobe; the address and the address-enable qualifier are caught in transparent latches, so the host may move its address lines once the strobe is released. The latched upper address bits are compared against a configurable base. When they match and the enable qualifier is low, the cycle reaches a 16-byte window. A 3-bit bank number picks which of eight banks that window shows. One slot of one bank is the data-path port, a first-in first-out word store.

Every access carries four active-low byte-lane enables, so byte, word and doubleword cycles all work. A 16-bit host reaches the upper word of a doubleword through address bit 1, which swaps the word lanes. Reads of the data path need a short fetch, and during it the ready output is held low for a fixed number of clock cycles. A separate active-low data chip-select skips the decode and the bank number entirely and moves whole 32-bit words to or from the data path.

Top module: `hbiu_top`

## Requirements
- R1: A register access takes effect only when the latched enable qualifier is low and latched address bits 15..4 equal `base_sel`; otherwise writes change nothing and `rdata` reads zero.
- R2: The address latch follows `host_a` and `aen` while `ads_n` is low and both `rd_n` and `wr_n` are high, and holds its value after `ads_n` rises or while a strobe is low.
- R3: `be_n[k]` low enables internal byte lane k (bits 8k+7..8k); a write changes only the enabled lanes.
- R4: A write to the slot at offset 0xC (address bits 3..2 equal 3) with all four lanes enabled updates only the bank number, leaving the three lower stored bytes of that slot untouched in every bank; partial writes there update the enabled lower bytes.
- R5: The bank number is 3 bits, resets to 0, is written through lane 3 (bits 26..24) of offset 0xC, reads back in bits 26..24 with bits 31..27 zero, and selects which of eight banks every other location in the window addresses.
- R6: With address bit 1 high, written host bits 15..0 land in internal lanes 3..2 and a read returns the internal upper word on both halves of `rdata`; with address bit 1 low no swap occurs.
- R7: The data port is bank 2, offset 0x8. A write pushes one word (disabled lanes as zero); a read returns the oldest word and removes it when the read strobe ends, so words leave in the order they arrived.
- R8: `ardy` is high out of reset and during register cycles; on a data-path read it falls as soon as `rd_n` falls, stays low across 2 rising clock edges and rises right after the second.
- R9: With `dcs_n` low an access goes to the data path regardless of the qualifier, base, bank number and byte enables, always moving all 32 bits with no word swap.
- R10: A write commits on the first clock edge after `wr_n` returns high and acts once per strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Active-low reset |
| base_sel | input | 12 | Base value for address bits 15..4 |
| host_a | input | 15 | Host address bits 15..1 |
| aen | input | 1 | Address enable qualifier, low to decode |
| ads_n | input | 1 | Address strobe, latch transparent while low |
| rd_n | input | 1 | Read strobe |
| wr_n | input | 1 | Write strobe |
| dcs_n | input | 1 | Data-path chip select, bypasses decode |
| be_n | input | 4 | Active-low byte-lane enables |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data |
| ardy | output | 1 | Ready, low while a data-path read waits |

## Verification
A wrong bank number or a lost latched address shows up at once on the next register read, because the bench reads locations whose contents differ between banks and slots. A bad word-swap or lane-enable path shows as a read value with the wrong halves or bytes in the first read after the write. A miscounted wait shows as `ardy` sampled at the wrong level in the two clock periods after the read strobe falls. Data-port pointer faults surface as words returned out of order on the following pops.

// File: rtl/hbiu_pkg.sv
package hbiu_pkg;

   localparam int LANES = 4;

   typedef logic [8*LANES-1:0] word_t;
   typedef logic [LANES-1:0]   lane_t;

   // upper word mirrored onto the lower half when bit 1 is set
   function automatic word_t swap_rd(word_t w, logic hi);
      return hi ? {w[31:16], w[31:16]} : w;
   endfunction

   // host low half steered to the upper lanes when bit 1 is set
   function automatic word_t swap_wr(word_t d, logic hi);
      return hi ? {d[15:0], d[15:0]} : d;
   endfunction

   function automatic word_t lane_mask(word_t d, lane_t en);
      word_t r;
      for (int k = 0; k < LANES; k++)
         r[8*k +: 8] = en[k] ? d[8*k +: 8] : 8'h00;
      return r;
   endfunction

endpackage

// File: rtl/hbiu_addr_latch.sv
module hbiu_addr_latch #(
   parameter int AW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:1] addr_in,
   input  logic          aen_in,
   input  logic          ads_n,
   input  logic          rd_n,
   input  logic          wr_n,
   output logic [AW-1:1] addr_q,
   output logic          aen_q
);

   logic open_w;
   assign open_w = !ads_n && rd_n && wr_n;

   always_latch begin
      if (open_w) begin
         addr_q = addr_in;
         aen_q  = aen_in;
      end
   end

   // R2
   latch_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ads_n && rd_n && wr_n) |-> (addr_q == addr_in && aen_q == aen_in));

   // R2
   latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ads_n && $past(ads_n)) |-> ($stable(addr_q) && $stable(aen_q)));

endmodule

// File: rtl/hbiu_ready_ctl.sv
module hbiu_ready_ctl #(
   parameter int WAIT_CYC = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic dp_rd,
   output logic ardy
);

   localparam int CW = $clog2(WAIT_CYC + 1);
   localparam logic [CW-1:0] LAST = CW'(WAIT_CYC);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (!dp_rd)
         cnt_q <= '0;
      else if (cnt_q != LAST)
         cnt_q <= cnt_q + 1'b1;
   end

   assign ardy = !dp_rd || (cnt_q == LAST);

   // R8
   no_spurious_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !dp_rd |-> ardy);

   // R8
   wait_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= LAST);

endmodule

// File: rtl/hbiu_reg_stub.sv
module hbiu_reg_stub
   import hbiu_pkg::*;
#(
   parameter int BANK_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [1:0]        slot,
   input  lane_t             be,
   input  word_t             wd,
   output word_t             rd_word,
   output logic [BANK_W-1:0] bank
);

   localparam int NB = 2 ** BANK_W;
   localparam int NS = 4;

   word_t mem_q [NB][NS];
   logic [BANK_W-1:0] bank_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bank_q <= '0;
         for (int b = 0; b < NB; b++)
            for (int s = 0; s < NS; s++)
               mem_q[b][s] <= '0;
      end else if (we) begin
         if (slot == 2'd3) begin
            if (be[3])
               bank_q <= wd[24 +: BANK_W];
            if (!(&be))
               for (int k = 0; k < 3; k++)
                  if (be[k]) mem_q[bank_q][3][8*k +: 8] <= wd[8*k +: 8];
         end else begin
            for (int k = 0; k < LANES; k++)
               if (be[k]) mem_q[bank_q][slot][8*k +: 8] <= wd[8*k +: 8];
         end
      end
   end

   always_comb begin
      rd_word = mem_q[bank_q][slot];
      if (slot == 2'd3) begin
         rd_word = '0;
         rd_word[23:0] = mem_q[bank_q][3][23:0];
         rd_word[24 +: BANK_W] = bank_q;
      end
   end

   assign bank = bank_q;

   // lower bytes of offset 0xC across every bank, for the check below
   logic [24*NB-1:0] low_c_all;
   for (genvar g = 0; g < NB; g++) begin : g_low
      assign low_c_all[24*g +: 24] = mem_q[g][3][23:0];
   end

   // R4
   dword_c_bank_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (we && slot == 2'd3 && (&be)) |=> $stable(low_c_all));

   // R5
   bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !we |=> $stable(bank_q));

endmodule

// File: rtl/hbiu_dp_fifo.sv
module hbiu_dp_fifo
   import hbiu_pkg::*;
#(
   parameter int DEPTH = 8
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  push,
   input  logic  pop,
   input  word_t wd,
   output word_t head
);

   localparam int PW = $clog2(DEPTH);

   word_t mem_q [DEPTH];
   logic [PW-1:0] wp_q, rp_q;
   logic [PW:0]   count_q;
   logic do_push, do_pop;

   assign do_push = push && (count_q != PW'(0) + (PW+1)'(DEPTH)) ;
   assign do_pop  = pop && (count_q != '0);

   always_ff @(posedge clk) begin
      if (do_push) mem_q[wp_q] <= wd;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp_q    <= '0;
         rp_q    <= '0;
         count_q <= '0;
      end else begin
         if (do_push) wp_q <= wp_q + 1'b1;
         if (do_pop)  rp_q <= rp_q + 1'b1;
         count_q <= count_q + (do_push ? 1'b1 : 1'b0) - (do_pop ? 1'b1 : 1'b0);
      end
   end

   assign head = mem_q[rp_q];

   // R7
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      count_q <= (PW+1)'(DEPTH));

   // R7
   push_grows_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (push && !pop && count_q == '0) |=> count_q == (PW+1)'(1));

endmodule

// File: rtl/hbiu_top.sv
module hbiu_top
   import hbiu_pkg::*;
#(
   parameter int AW         = 16,
   parameter int BANK_W     = 3,
   parameter int WAIT_CYC   = 2,
   parameter int FIFO_DEPTH = 8,
   parameter int DP_BANK    = 2,
   parameter int DP_SLOT    = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-5:0] base_sel,
   input  logic [AW-1:1] host_a,
   input  logic          aen,
   input  logic          ads_n,
   input  logic          rd_n,
   input  logic          wr_n,
   input  logic          dcs_n,
   input  logic [3:0]    be_n,
   input  logic [31:0]   wdata,
   output logic [31:0]   rdata,
   output logic          ardy
);

   if (AW < 6) begin : g_bad_aw
      $error("hbiu_top: AW too small");
   end
   if (WAIT_CYC < 1) begin : g_bad_wait
      $error("hbiu_top: WAIT_CYC must be at least 1");
   end
   if (DP_BANK >= 2 ** BANK_W || DP_SLOT > 2) begin : g_bad_dp
      $error("hbiu_top: data port location outside window");
   end
   if (FIFO_DEPTH < 2 || (FIFO_DEPTH & (FIFO_DEPTH - 1)) != 0) begin : g_bad_depth
      $error("hbiu_top: FIFO_DEPTH must be a power of two");
   end

   logic [AW-1:1]     a_l;
   logic              aen_l;
   logic [BANK_W-1:0] bank;
   logic [1:0]        slot;
   logic              a1, dec_hit, port_dp, dp_rd;
   word_t             reg_rd, head, wd_int, push_wd;
   lane_t             be_int, cap_be_n;
   word_t             cap_d;
   logic              wr_q, rd_q, cap_dcs, rd_dp_q;
   logic              wr_done, push, pop, reg_we;

   hbiu_addr_latch #(.AW(AW)) u_lat (
      .clk(clk), .rst_n(rst_n), .addr_in(host_a), .aen_in(aen),
      .ads_n(ads_n), .rd_n(rd_n), .wr_n(wr_n),
      .addr_q(a_l), .aen_q(aen_l)
   );

   assign slot    = a_l[3:2];
   assign a1      = a_l[1];
   assign dec_hit = !aen_l && (a_l[AW-1:4] == base_sel);
   assign port_dp = dec_hit && (bank == BANK_W'(DP_BANK)) && (slot == 2'(DP_SLOT));
   assign dp_rd   = !rd_n && (!dcs_n || port_dp);

   // strobe sampling and write capture
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_q     <= 1'b1;
         rd_q     <= 1'b1;
         rd_dp_q  <= 1'b0;
         cap_dcs  <= 1'b1;
         cap_be_n <= '1;
         cap_d    <= '0;
      end else begin
         wr_q    <= wr_n;
         rd_q    <= rd_n;
         rd_dp_q <= dp_rd;
         if (!wr_n) begin
            cap_dcs  <= dcs_n;
            cap_be_n <= be_n;
            cap_d    <= wdata;
         end
      end
   end

   assign wr_done = wr_n && !wr_q;
   assign pop     = rd_n && !rd_q && rd_dp_q;

   always_comb begin
      if (!cap_dcs) begin
         wd_int = cap_d;
         be_int = '1;
      end else begin
         wd_int = swap_wr(cap_d, a1);
         be_int = ~cap_be_n;
      end
   end

   assign push    = wr_done && (!cap_dcs || port_dp);
   assign reg_we  = wr_done && cap_dcs && dec_hit && !port_dp;
   assign push_wd = lane_mask(wd_int, be_int);

   hbiu_reg_stub #(.BANK_W(BANK_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .we(reg_we), .slot(slot), .be(be_int),
      .wd(wd_int), .rd_word(reg_rd), .bank(bank)
   );

   hbiu_dp_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
      .clk(clk), .rst_n(rst_n), .push(push), .pop(pop),
      .wd(push_wd), .head(head)
   );

   hbiu_ready_ctl #(.WAIT_CYC(WAIT_CYC)) u_rdy (
      .clk(clk), .rst_n(rst_n), .dp_rd(dp_rd), .ardy(ardy)
   );

   always_comb begin
      if (!dcs_n)
         rdata = head;
      else if (!dec_hit)
         rdata = '0;
      else
         rdata = swap_rd(port_dp ? head : reg_rd, a1);
   end

   // R9
   exclusive_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({reg_we, push}));

   // R10
   single_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we || push) |=> !(reg_we || push));

endmodule

// File: tb/hbiu_top_tb_top.sv
module hbiu_top_tb_top;

   localparam logic [11:0] BASE = 12'h030;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] base_sel = BASE;
   logic [15:1] host_a = '1;
   logic        aen = 1'b1;
   logic        ads_n = 1'b1;
   logic        rd_n = 1'b1;
   logic        wr_n = 1'b1;
   logic        dcs_n = 1'b1;
   logic [3:0]  be_n = '1;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        ardy;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   hbiu_top dut_i (
      .clk(clk), .rst_n(rst_n), .base_sel(base_sel), .host_a(host_a),
      .aen(aen), .ads_n(ads_n), .rd_n(rd_n), .wr_n(wr_n), .dcs_n(dcs_n),
      .be_n(be_n), .wdata(wdata), .rdata(rdata), .ardy(ardy)
   );

   function automatic logic [15:0] loc(input logic [1:0] slot, input logic hi);
      return {BASE, slot, hi, 1'b0};
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic latch_addr(input logic [15:0] a, input logic q);
      @(negedge clk);
      host_a = a[15:1];
      aen    = q;
      ads_n  = 1'b0;
      @(negedge clk);
      ads_n  = 1'b1;
      @(negedge clk);
      host_a = '1;     // R2: moving lines after the strobe must not matter
      aen    = 1'b1;
   endtask

   task automatic do_write(input logic [31:0] d, input logic [3:0] ben, input logic cs_n);
      @(negedge clk);
      wdata = d;
      be_n  = ben;
      dcs_n = cs_n;
      wr_n  = 1'b0;
      repeat (2) @(negedge clk);
      wr_n  = 1'b1;
      repeat (2) @(negedge clk);
      dcs_n = 1'b1;
      be_n  = '1;
      wdata = '0;
   endtask

   task automatic do_read(input logic cs_n, output logic [31:0] d,
                          output logic r0, output logic r1, output logic r2);
      @(negedge clk);
      dcs_n = cs_n;
      rd_n  = 1'b0;
      #1 r0 = ardy;
      @(negedge clk);
      r1 = ardy;
      @(negedge clk);
      r2 = ardy;
      d  = rdata;
      rd_n = 1'b1;
      repeat (2) @(negedge clk);
      dcs_n = 1'b1;
   endtask

   task automatic set_bank(input logic [2:0] b);
      latch_addr(loc(2'd3, 1'b0), 1'b0);
      do_write({5'b0, b, 24'h0}, 4'b0111, 1'b1);
   endtask

   task automatic reg_read_chk(input string tag, input logic [15:0] a, input logic [31:0] exp);
      logic [31:0] d;
      logic r0, r1, r2;
      latch_addr(a, 1'b0);
      do_read(1'b1, d, r0, r1, r2);
      chk(tag, d, exp);
   endtask

   task automatic t_reset;
      chk("R8 ardy after reset", {31'b0, ardy}, 32'h1);
      reg_read_chk("R5 bank number resets to 0", loc(2'd3, 1'b0), 32'h0);
      reg_read_chk("R3 slot0 resets to 0", loc(2'd0, 1'b0), 32'h0);
   endtask

   task automatic t_lanes;
      logic [31:0] d;
      logic r0, r1, r2;
      latch_addr(loc(2'd0, 1'b0), 1'b0);
      do_write(32'h11223344, 4'b0000, 1'b1);
      reg_read_chk("R3 doubleword write", loc(2'd0, 1'b0), 32'h11223344);
      latch_addr(loc(2'd0, 1'b0), 1'b0);
      do_write(32'hEEEEAAEE, 4'b1101, 1'b1);
      latch_addr(loc(2'd0, 1'b0), 1'b0);
      do_read(1'b1, d, r0, r1, r2);
      chk("R3 byte lane 1 write", d, 32'h1122AA44);
      chk("R8 ardy stays high on register read", {29'b0, r0, r1, r2}, 32'h7);
   endtask

   task automatic t_decode;
      logic [31:0] d;
      logic r0, r1, r2;
      latch_addr(loc(2'd1, 1'b0), 1'b1);
      do_write(32'hDEADBEEF, 4'b0000, 1'b1);
      reg_read_chk("R1 write with qualifier high ignored", loc(2'd1, 1'b0), 32'h0);
      latch_addr({12'h031, 4'h4}, 1'b0);
      do_write(32'h12345678, 4'b0000, 1'b1);
      reg_read_chk("R1 write to other base ignored", loc(2'd1, 1'b0), 32'h0);
      latch_addr(loc(2'd0, 1'b0), 1'b1);
      do_read(1'b1, d, r0, r1, r2);
      chk("R1 read with qualifier high gives zero", d, 32'h0);
   endtask

   task automatic t_bank;
      set_bank(3'd5);
      reg_read_chk("R5 bank number reads back", loc(2'd3, 1'b0), 32'h05000000);
      reg_read_chk("R5 bank 5 slot0 empty", loc(2'd0, 1'b0), 32'h0);
      latch_addr(loc(2'd0, 1'b0), 1'b0);
      do_write(32'hCAFEF00D, 4'b0000, 1'b1);
      set_bank(3'd0);
      reg_read_chk("R5 bank 0 slot0 kept", loc(2'd0, 1'b0), 32'h1122AA44);
      set_bank(3'd5);
      reg_read_chk("R5 bank 5 slot0 written", loc(2'd0, 1'b0), 32'hCAFEF00D);
      set_bank(3'd0);
   endtask

   task automatic t_offset_c;
      latch_addr(loc(2'd3, 1'b0), 1'b0);
      do_write(32'h00ABCDEF, 4'b1000, 1'b1);
      reg_read_chk("R4 partial write to offset 0xC", loc(2'd3, 1'b0), 32'h00ABCDEF);
      latch_addr(loc(2'd3, 1'b0), 1'b0);
      do_write(32'h02123456, 4'b0000, 1'b1);
      reg_read_chk("R4 doubleword at 0xC sets bank only", loc(2'd3, 1'b0), 32'h02000000);
      set_bank(3'd0);
      reg_read_chk("R4 lower bytes of 0xC kept", loc(2'd3, 1'b0), 32'h00ABCDEF);
   endtask

   task automatic t_swap;
      latch_addr(loc(2'd1, 1'b1), 1'b0);
      do_write(32'h0000BEEF, 4'b0011, 1'b1);
      reg_read_chk("R6 high word write lands in lanes 3..2", loc(2'd1, 1'b0), 32'hBEEF0000);
      reg_read_chk("R6 high word read mirrored", loc(2'd1, 1'b1), 32'hBEEFBEEF);
      latch_addr(loc(2'd1, 1'b0), 1'b0);
      do_write(32'h00001234, 4'b1100, 1'b1);
      reg_read_chk("R6 low word no swap", loc(2'd1, 1'b0), 32'hBEEF1234);
   endtask

   task automatic t_latch_closed;
      latch_addr(loc(2'd0, 1'b0), 1'b0);
      @(negedge clk);
      rd_n = 1'b0;
      @(negedge clk);
      host_a = loc(2'd1, 1'b0) >> 1;
      aen    = 1'b0;
      ads_n  = 1'b0;
      @(negedge clk);
      chk("R2 latch closed while strobe low", rdata, 32'h1122AA44);
      ads_n = 1'b1;
      rd_n  = 1'b1;
      repeat (2) @(negedge clk);
      host_a = '1;
      aen    = 1'b1;
   endtask

   task automatic t_data_port;
      logic [31:0] d;
      logic r0, r1, r2;
      set_bank(3'd2);
      latch_addr(loc(2'd2, 1'b0), 1'b0);
      do_write(32'h11110001, 4'b0000, 1'b1);
      do_write(32'hFFFF5678, 4'b1100, 1'b1);
      do_read(1'b1, d, r0, r1, r2);
      chk("R7 first word out", d, 32'h11110001);
      chk("R8 ardy low two edges then high", {29'b0, r0, r1, r2}, 32'h1);
      do_read(1'b1, d, r0, r1, r2);
      chk("R7 second word masked lanes", d, 32'h00005678);
      chk("R10 one push per write strobe (port now empty of old words)", {31'b0, r2}, 32'h1);
      set_bank(3'd0);
   endtask

   task automatic t_chip_select;
      logic [31:0] d;
      logic r0, r1, r2;
      latch_addr(loc(2'd0, 1'b1), 1'b1);
      do_write(32'hA5A5A5A5, 4'b1110, 1'b0);
      do_write(32'h5A5A0F0F, 4'b1111, 1'b0);
      do_read(1'b0, d, r0, r1, r2);
      chk("R9 select bypass full word, no swap", d, 32'hA5A5A5A5);
      chk("R9 select read waits like data port", {29'b0, r0, r1, r2}, 32'h1);
      do_read(1'b0, d, r0, r1, r2);
      chk("R9 byte enables ignored on select", d, 32'h5A5A0F0F);
      reg_read_chk("R9 select writes leave registers alone", loc(2'd0, 1'b0), 32'h1122AA44);
      set_bank(3'd2);
      latch_addr(loc(2'd2, 1'b0), 1'b0);
      do_write(32'h77778888, 4'b0000, 1'b1);
      do_read(1'b0, d, r0, r1, r2);
      chk("R10 decoded push seen once through select", d, 32'h77778888);
      set_bank(3'd0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_reset();
      t_lanes();
      t_decode();
      t_bank();
      t_offset_c();
      t_swap();
      t_latch_closed();
      t_data_port();
      t_chip_select();
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=running expected=done");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule